// File: doc/BRIEF.md
# Stepper Motor Linear Ramp Pulse Generator

This block drives a stepper motor toward a commanded position. It emits step pulses and a direction level, and it shapes the interval between pulses into a linear speed ramp. Each move starts slowly, speeds up by one ramp index per pulse, holds the top rate, and then slows down so that the last pulses come at low speed. The period of each pulse is computed from two control values and a ramp index k, which runs from 2 (slowest) to 13 (fastest). No table is stored: period = base − k·slope, counted in timebase ticks.

The timebase tick is a one-cycle enable that a prescaler outside the block produces (for example the system clock divided by 64). Software writes the two control values and a target and pulses start. The block then runs the move to its end on its own and reports through busy. With base 19164, slope 1390 and a 262144 Hz tick, the ramp runs from about 16 to about 240 steps per second.

Top module: `stepper_ramp`

## Requirements
- R1: After reset, position is 0 and step, busy and dir are 0.
- R2: A start pulse while idle with target different from position sets busy and latches target, base and slope. dir becomes 1 when target is greater than position (signed) and 0 otherwise, and it holds its value until busy clears.
- R3: A start pulse while idle with target equal to position has no effect: busy stays 0 and position does not change.
- R4: Each pulse of a move fires on the P-th tick counted after the previous pulse, or after the start edge for the first pulse. P = base − k·slope, with the latched values. When that difference is zero or negative, P is 1.
- R5: k is 2 for the first pulse of a move. After each pulse, k rises by one, up to 13, unless the deceleration rule of R6 applies.
- R6: After each pulse, if the remaining distance is nonzero and no greater than k − 2, k falls by one, never below 2.
- R7: step goes high on the tick that fires a pulse and stays high until the next tick. It stays high across that tick only if that tick fires another pulse.
- R8: Each pulse changes position by exactly one toward the target, in the same cycle that step rises. busy clears on the pulse that makes position equal to target.
- R9: start and target are ignored while busy. The move ends at the target latched when it started.
- R10: Cycles without a tick change neither position, step nor the ramp timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timebase enable, one cycle wide |
| start | input | 1 | Begin a move toward target |
| rate_base | input | CW | Base period term (base) |
| rate_slope | input | CW | Per-index period decrement (slope) |
| target | input | PW | Signed target position |
| step | output | 1 | Step pulse, one tick long |
| dir | output | 1 | 1 = moving toward higher positions |
| position | output | PW | Signed current position |
| busy | output | 1 | Move in progress |

## Verification
The bench builds the block with its default 16-bit widths and keeps the control values tiny: base of 20 to 40 ticks and slope of 1 to 5. A tick arrives every second clock, so a whole ramp lasts only a few hundred cycles. These values let the bench sweep move lengths from 0 to 40 steps in both directions, including moves too short to reach k = 13 and moves that end while still accelerating. One configuration has a period that goes negative partway up the ramp, which exercises the one-tick clamp. Each inter-pulse interval is compared with an arithmetic model of the k sequence, and one move has a second start issued while busy.

// File: rtl/stepper_ramp.sv
module stepper_ramp #(
  parameter int CW   = 16,
  parameter int PW   = 16,
  parameter int KMIN = 2,
  parameter int KMAX = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 start,
  input  logic [CW-1:0]        rate_base,
  input  logic [CW-1:0]        rate_slope,
  input  logic signed [PW-1:0] target,
  output logic                 step,
  output logic                 dir,
  output logic signed [PW-1:0] position,
  output logic                 busy
);
  localparam int KW  = $clog2(KMAX + 1);
  localparam int PRW = CW + KW + 1;

  logic [CW-1:0]        base_q, slope_q, cnt_q, per;
  logic [KW-1:0]        k_q;
  logic signed [PW-1:0] pos_q, tgt_q, pos_nx;
  logic                 busy_q, dir_q, step_q, fire;
  logic [PRW-1:0]       raw;
  logic signed [PW:0]   rem;

  always_comb begin
    raw = PRW'(base_q) - PRW'(slope_q) * PRW'(k_q);
    per = (raw[PRW-1] || !(|raw)) ? CW'(1) : raw[CW-1:0];
  end

  assign fire   = busy_q && tick && (({1'b0, cnt_q} + 1'b1) >= {1'b0, per});
  assign pos_nx = dir_q ? pos_q + 1'b1 : pos_q - 1'b1;
  assign rem    = dir_q ? ({tgt_q[PW-1], tgt_q} - {pos_nx[PW-1], pos_nx})
                        : ({pos_nx[PW-1], pos_nx} - {tgt_q[PW-1], tgt_q});

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0; slope_q <= '0; cnt_q <= '0; k_q <= KW'(KMIN);
      pos_q <= '0; tgt_q <= '0; busy_q <= 1'b0; dir_q <= 1'b0; step_q <= 1'b0;
    end else begin
      if (tick) step_q <= fire;
      if (!busy_q) begin
        if (start && target != pos_q) begin
          busy_q  <= 1'b1;
          dir_q   <= target > pos_q;
          tgt_q   <= target;
          base_q  <= rate_base;
          slope_q <= rate_slope;
          k_q     <= KW'(KMIN);
          cnt_q   <= '0;
        end
      end else if (tick) begin
        if (fire) begin
          cnt_q <= '0;
          pos_q <= pos_nx;
          if (rem == '0) busy_q <= 1'b0;
          else if (rem[PW-1:0] <= PW'(k_q - KW'(KMIN))) begin
            if (k_q > KW'(KMIN)) k_q <= k_q - 1'b1;
          end else if (k_q < KW'(KMAX)) k_q <= k_q + 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign step     = step_q;
  assign dir      = dir_q;
  assign position = pos_q;
  assign busy     = busy_q;

  a_r8_unit_move: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(step_q) |-> ((pos_q - $past(pos_q)) == 1 || ($past(pos_q) - pos_q) == 1));
  a_r8_move_only_on_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos_q) |-> step_q);
  a_r8_done_at_target: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> pos_q == tgt_q);
  a_r2_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(dir_q));
  a_r5_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (k_q >= KW'(KMIN) && k_q <= KW'(KMAX)));
  a_r10_idle_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pos_q) && $stable(step_q)));
endmodule

// File: tb/tb_stepper_ramp.sv
module tb_stepper_ramp;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [15:0] rate_base = '0, rate_slope = '0;
  logic signed [15:0] target = '0;
  logic step, dir, busy;
  logic signed [15:0] position;

  int checks = 0, errors = 0, epos = 0;
  logic lt;

  stepper_ramp dut (.clk(clk), .rst_n(rst_n), .tick(tick), .start(start),
    .rate_base(rate_base), .rate_slope(rate_slope), .target(target),
    .step(step), .dir(dir), .position(position), .busy(busy));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pf(input int c0, input int c1, input int k);
    int p = c1 - k * c0;
    return (p < 1) ? 1 : p;
  endfunction

  task automatic adv();
    @(negedge clk);
    lt = tick;
    tick = ~tick;
  endtask

  task automatic run_move(input int c0, input int c1, input int tg, input bit retarget);
    int k, per, cntt, rem, guard;
    bit d, fire, prev_step;
    adv();
    start = 1'b1; target = 16'(tg); rate_base = 16'(c1); rate_slope = 16'(c0);
    adv();
    start = 1'b0;
    chk(busy == (tg != epos), "R2 R3 busy after start", busy, tg != epos);
    if (tg == epos) begin
      adv();
      chk(position == epos, "R3 position unchanged", position, epos);
      chk(busy == 1'b0, "R3 stays idle", busy, 0);
      return;
    end
    d = tg > epos;
    chk(dir == d, "R2 direction", dir, d);
    k = 2; cntt = 0; per = pf(c0, c1, k); prev_step = step; guard = 0;
    while (guard < 20000) begin
      adv();
      guard++;
      start = retarget && guard == 3;
      if (start) target = 16'(-tg - 5);
      if (lt) begin
        cntt++;
        fire = cntt >= per;
        chk(step == fire, "R4,R5,R6,R7 pulse timing", step, fire);
        if (fire) begin
          epos += d ? 1 : -1;
          chk(position == epos, "R8 position", position, epos);
          rem = d ? tg - epos : epos - tg;
          chk(busy == (rem != 0), "R8 busy", busy, rem != 0);
          chk(dir == d, "R2 direction held", dir, d);
          if (rem == 0) break;
          if (rem <= k - 2) begin
            if (k > 2) k--;
          end else if (k < 13) k++;
          cntt = 0;
          per = pf(c0, c1, k);
        end
      end else begin
        chk(step == prev_step, "R10 step without tick", step, prev_step);
        chk(position == epos, "R10 position without tick", position, epos);
      end
      prev_step = step;
    end
    start = 1'b0;
    adv(); adv();
    chk(step == 1'b0, "R7 pulse ends after one tick", step, 0);
    chk(position == tg, retarget ? "R9 ignored retarget" : "R8 final position", position, tg);
    chk(busy == 1'b0, "R8 idle at end", busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) adv();
    rst_n = 1'b1;
    adv();
    chk(position == 0, "R1 reset position", position, 0);
    chk(step == 0 && busy == 0 && dir == 0, "R1 reset flags", {step, busy, dir}, 0);
    run_move(2, 30, 0, 1'b0);
    for (int cfg = 0; cfg < 3; cfg++) begin
      int c0 = (cfg == 0) ? 2 : (cfg == 1) ? 1 : 5;
      int c1 = (cfg == 0) ? 30 : (cfg == 1) ? 20 : 40;
      for (int dd = 0; dd <= 20; dd++) begin
        run_move(c0, c1, dd, 1'b0);
        run_move(c0, c1, -dd, 1'b0);
      end
    end
    run_move(2, 30, 25, 1'b1);
    run_move(2, 30, 25, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule